// File: doc/BRIEF.md
# Legacy Interrupt Router for the Processor-Side Bridge

This block sits at the processor side of the bridge and steers every interrupt request message arriving from the I/O fabric. The most significant bit of the 4-bit message type chooses the path. When it is set, the message is a virtual wire. Legacy external-interrupt requests raise the processor's INTR level, and legacy NMI requests pulse the NMI pin. When it is clear, the message goes out unchanged on the forwarded-message port toward the APIC-style delivery logic. Codes whose low three bits are all ones are end-of-interrupt codes and are never taken as requests.

The block also serves the processor's interrupt-acknowledge cycle. A request from the processor becomes a single one-byte read at the base of the reserved acknowledge window. The 8-bit vector in the read response is handed back to the processor, and INTR drops in the same cycle. When the processor signals end of service, the block emits an EOI message that carries the serviced vector. The message is broadcast to every downstream agent.

The acknowledge controller has four named states:
- `ACK_IDLE`: waits. It goes to `ACK_ISSUE` on an acknowledge request.
- `ACK_ISSUE`: drives the read for one cycle, then always goes to `ACK_WAIT`.
- `ACK_WAIT`: goes to `ACK_RETURN` when a read response arrives.
- `ACK_RETURN`: presents the vector for one cycle, then always goes back to `ACK_IDLE`.

Top module: `irq_path_router`

## Requirements
- R1: A message of type 4'b1110 raises `cpu_intr` in the next cycle. The level stays high until `cpu_inta_done` rises, and it falls in that same cycle.
- R2: A message whose type has bit 3 clear and low bits other than 3'b111 appears on the forwarded port one cycle later. Type, vector, destination, destination mode and EOI-request flag are unchanged. This covers 4'b0110 and 4'b0011. Neither `cpu_intr` nor `cpu_nmi` reacts to such a message.
- R3: Each message of type 4'b1011 yields its own one-cycle high pulse on `cpu_nmi`, starting one cycle after receipt. Consecutive messages produce pulses separated by at least one low cycle, and up to 2^NMI_OWED_W-1 pulses can be owed.
- R4: An acknowledge request taken in `ACK_IDLE` drives `rd_req_valid` high for exactly one cycle, starting one cycle later. During that cycle `rd_req_addr` = 40'hFD_F900_0000 and `rd_req_bytemask` = 4'b0001. Both are zero whenever `rd_req_valid` is low.
- R5: A read response taken in `ACK_WAIT` drives `cpu_inta_done` high for one cycle, starting one cycle later. During that cycle `cpu_inta_vector` equals the response byte. Otherwise `cpu_inta_vector` is zero.
- R6: An acknowledge request that arrives while any earlier acknowledge is still in progress is ignored and produces no further read.
- R7: A read response that arrives when no read is outstanding is ignored and produces no `cpu_inta_done`.
- R8: A message whose type low bits are 3'b111 is dropped. It is not forwarded and does not change `cpu_intr` or `cpu_nmi`.
- R9: A message with type bit 3 set, other than 4'b1110 or 4'b1011, is dropped with no effect on any output.
- R10: `cpu_eoi_valid` produces a forwarded message one cycle later, with type 4'b0111, the given vector, destination all ones, physical destination mode and a clear EOI-request flag. If a forwardable message arrives in the same cycle, that message goes out first and the EOI follows in the next free cycle.
- R11: While reset is asserted, every output is zero.
- R12: If a 4'b1110 message arrives in the same cycle as the read response that completes an acknowledge, `cpu_intr` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | 1 | Incoming interrupt message present |
| msg_type | input | 4 | Message type code |
| msg_vector | input | 8 | Message vector |
| msg_dest_logical | input | 1 | Destination mode, 1 = logical |
| msg_eoi_req | input | 1 | Message asks for an EOI |
| msg_dest | input | DEST_W | Message destination |
| cpu_eoi_valid | input | 1 | Processor finished servicing a vector |
| cpu_eoi_vector | input | 8 | Serviced vector |
| cpu_inta_req | input | 1 | Processor interrupt-acknowledge request |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_data | input | 8 | Read response byte |
| cpu_intr | output | 1 | INTR level to the processor |
| cpu_nmi | output | 1 | NMI pulse to the processor |
| cpu_inta_done | output | 1 | Acknowledge result valid |
| cpu_inta_vector | output | 8 | Acknowledge vector |
| fwd_valid | output | 1 | Forwarded message present |
| fwd_type | output | 4 | Forwarded type |
| fwd_vector | output | 8 | Forwarded vector |
| fwd_dest_logical | output | 1 | Forwarded destination mode |
| fwd_eoi_req | output | 1 | Forwarded EOI-request flag |
| fwd_dest | output | DEST_W | Forwarded destination |
| rd_req_valid | output | 1 | Acknowledge read request |
| rd_req_addr | output | 40 | Read address |
| rd_req_bytemask | output | 4 | Read byte mask |

## Verification
Every result here is one register away from its cause:
- INTR, the NMI pulse, the forwarded message and the read request each appear in the cycle after the edge that sampled their input.
- The acknowledge result appears one cycle after the response edge.
- An owed NMI pulse or a deferred EOI shifts out one further cycle per earlier occupant.

The bench drives inputs on the falling edge and advances a behavioural model on the rising edge with the same inputs. It then compares every output against that model on the next falling edge. A late or early result therefore shows up as a miscompare in exactly the cycle it is due.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;

    localparam logic [3:0]  MT_LEGACY_EXTINT = 4'b1110;
    localparam logic [3:0]  MT_LEGACY_NMI    = 4'b1011;
    localparam logic [3:0]  MT_EOI           = 4'b0111;
    localparam logic [2:0]  MT_EOI_LOW       = 3'b111;
    localparam logic [39:0] ACK_WINDOW_BASE  = 40'hFD_F900_0000;
    localparam logic [3:0]  ACK_BYTEMASK     = 4'b0001;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_ISSUE,
        ACK_WAIT,
        ACK_RETURN
    } ack_state_e;

    typedef enum logic [1:0] {
        CLS_DROP,
        CLS_FWD,
        CLS_PIN_INTR,
        CLS_PIN_NMI
    } msg_class_e;

endpackage

// File: rtl/irq_msg_classify.sv
`timescale 1ns/1ps
module irq_msg_classify
    import irq_router_pkg::*;
(
    input  logic       valid,
    input  logic [3:0] mtype,
    output msg_class_e cls
);

    always_comb begin
        cls = CLS_DROP;
        if (valid) begin
            unique case (mtype[3])
                1'b0: cls = (mtype[2:0] == MT_EOI_LOW) ? CLS_DROP : CLS_FWD;
                1'b1: begin
                    if (mtype == MT_LEGACY_EXTINT)   cls = CLS_PIN_INTR;
                    else if (mtype == MT_LEGACY_NMI) cls = CLS_PIN_NMI;
                    else                             cls = CLS_DROP;
                end
                default: cls = CLS_DROP;
            endcase
        end
    end

endmodule

// File: rtl/irq_nmi_pulser.sv
`timescale 1ns/1ps
module irq_nmi_pulser #(
    parameter int OWED_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic nmi
);

    localparam logic [OWED_W:0] OWED_MAX = {1'b0, {OWED_W{1'b1}}};

    logic [OWED_W-1:0] owed_q;
    logic              nmi_q;
    logic [OWED_W:0]   total;
    logic [OWED_W:0]   total_dec;

    always_comb begin
        total = {1'b0, owed_q} + {{OWED_W{1'b0}}, hit};
        if (total > OWED_MAX) total = OWED_MAX;
        total_dec = total - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed_q <= '0;
            nmi_q  <= 1'b0;
        end else if (!nmi_q && (total != '0)) begin
            nmi_q  <= 1'b1;
            owed_q <= total_dec[OWED_W-1:0];
        end else begin
            nmi_q  <= 1'b0;
            owed_q <= total[OWED_W-1:0];
        end
    end

    assign nmi = nmi_q;

    // R3
    nmi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_q |=> !nmi_q);

endmodule

// File: rtl/irq_ack_fsm.sv
`timescale 1ns/1ps
module irq_ack_fsm
    import irq_router_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inta_req,
    input  logic              rsp_valid,
    input  logic [VEC_W-1:0]  rsp_data,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [3:0]        rd_req_bytemask,
    output logic              inta_done,
    output logic [VEC_W-1:0]  inta_vector,
    output logic              vector_taken
);

    ack_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:   if (inta_req)  state_d = ACK_ISSUE;
            ACK_ISSUE:                 state_d = ACK_WAIT;
            ACK_WAIT:   if (rsp_valid) state_d = ACK_RETURN;
            ACK_RETURN:                state_d = ACK_IDLE;
            default:                   state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                vec_q <= '0;
        else if (state_q == ACK_WAIT && rsp_valid) vec_q <= rsp_data;
    end

    always_comb begin
        rd_req_valid    = 1'b0;
        rd_req_addr     = '0;
        rd_req_bytemask = '0;
        inta_done       = 1'b0;
        inta_vector     = '0;
        vector_taken    = 1'b0;
        unique case (state_q)
            ACK_ISSUE: begin
                rd_req_valid    = 1'b1;
                rd_req_addr     = ADDR_W'(ACK_WINDOW_BASE);
                rd_req_bytemask = ACK_BYTEMASK;
            end
            ACK_WAIT:   vector_taken = rsp_valid;
            ACK_RETURN: begin
                inta_done   = 1'b1;
                inta_vector = vec_q;
            end
            default: ;
        endcase
    end

    // R4
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> !rd_req_valid);

    // R6
    no_read_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ACK_IDLE) |=> !rd_req_valid);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta_done |=> !inta_done);

    // R7
    stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACK_IDLE) |=> !inta_done);

endmodule

// File: rtl/irq_path_router.sv
`timescale 1ns/1ps
module irq_path_router
    import irq_router_pkg::*;
#(
    parameter int DEST_W     = 8,
    parameter int VEC_W      = 8,
    parameter int ADDR_W     = 40,
    parameter int NMI_OWED_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [3:0]        msg_type,
    input  logic [VEC_W-1:0]  msg_vector,
    input  logic              msg_dest_logical,
    input  logic              msg_eoi_req,
    input  logic [DEST_W-1:0] msg_dest,
    input  logic              cpu_eoi_valid,
    input  logic [VEC_W-1:0]  cpu_eoi_vector,
    input  logic              cpu_inta_req,
    input  logic              rd_rsp_valid,
    input  logic [VEC_W-1:0]  rd_rsp_data,
    output logic              cpu_intr,
    output logic              cpu_nmi,
    output logic              cpu_inta_done,
    output logic [VEC_W-1:0]  cpu_inta_vector,
    output logic              fwd_valid,
    output logic [3:0]        fwd_type,
    output logic [VEC_W-1:0]  fwd_vector,
    output logic              fwd_dest_logical,
    output logic              fwd_eoi_req,
    output logic [DEST_W-1:0] fwd_dest,
    output logic              rd_req_valid,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [3:0]        rd_req_bytemask
);

    msg_class_e       cls;
    logic             vector_taken;
    logic             intr_q;
    logic             eoi_pend_q;
    logic [VEC_W-1:0] eoi_pend_vec_q;

    irq_msg_classify u_classify (
        .valid (msg_valid),
        .mtype (msg_type),
        .cls   (cls)
    );

    irq_nmi_pulser #(.OWED_W(NMI_OWED_W)) u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (cls == CLS_PIN_NMI),
        .nmi   (cpu_nmi)
    );

    irq_ack_fsm #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_ack (
        .clk             (clk),
        .rst_n           (rst_n),
        .inta_req        (cpu_inta_req),
        .rsp_valid       (rd_rsp_valid),
        .rsp_data        (rd_rsp_data),
        .rd_req_valid    (rd_req_valid),
        .rd_req_addr     (rd_req_addr),
        .rd_req_bytemask (rd_req_bytemask),
        .inta_done       (cpu_inta_done),
        .inta_vector     (cpu_inta_vector),
        .vector_taken    (vector_taken)
    );

    // INTR virtual wire: a new request wins over the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  intr_q <= 1'b0;
        else if (cls == CLS_PIN_INTR) intr_q <= 1'b1;
        else if (vector_taken)        intr_q <= 1'b0;
    end
    assign cpu_intr = intr_q;

    // Forward path: fabric messages first, EOI takes the next free slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid        <= 1'b0;
            fwd_type         <= '0;
            fwd_vector       <= '0;
            fwd_dest_logical <= 1'b0;
            fwd_eoi_req      <= 1'b0;
            fwd_dest         <= '0;
            eoi_pend_q       <= 1'b0;
            eoi_pend_vec_q   <= '0;
        end else begin
            fwd_valid <= 1'b0;
            if (cls == CLS_FWD) begin
                fwd_valid        <= 1'b1;
                fwd_type         <= msg_type;
                fwd_vector       <= msg_vector;
                fwd_dest_logical <= msg_dest_logical;
                fwd_eoi_req      <= msg_eoi_req;
                fwd_dest         <= msg_dest;
                if (cpu_eoi_valid) begin
                    eoi_pend_q     <= 1'b1;
                    eoi_pend_vec_q <= cpu_eoi_vector;
                end
            end else if (eoi_pend_q || cpu_eoi_valid) begin
                fwd_valid        <= 1'b1;
                fwd_type         <= MT_EOI;
                fwd_vector       <= eoi_pend_q ? eoi_pend_vec_q : cpu_eoi_vector;
                fwd_dest_logical <= 1'b0;
                fwd_eoi_req      <= 1'b0;
                fwd_dest         <= '1;
                eoi_pend_q       <= eoi_pend_q && cpu_eoi_valid;
                eoi_pend_vec_q   <= cpu_eoi_vector;
            end
        end
    end

    // R1
    intr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_intr) |-> $past(msg_valid && msg_type == MT_LEGACY_EXTINT));

    // R2
    fwd_low_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !fwd_type[3]);

    // R8
    eoi_code_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type[2:0] == MT_EOI_LOW && !cpu_eoi_valid && !eoi_pend_q)
            |=> !fwd_valid);

    // R12
    intr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == MT_LEGACY_EXTINT) |=> cpu_intr);

endmodule

// File: tb/irq_path_router_bench.sv
`timescale 1ns/1ps
module irq_path_router_bench;

    localparam int DEST_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [3:0]  msg_type = '0;
    logic [7:0]  msg_vector = '0;
    logic        msg_dest_logical = 1'b0;
    logic        msg_eoi_req = 1'b0;
    logic [7:0]  msg_dest = '0;
    logic        cpu_eoi_valid = 1'b0;
    logic [7:0]  cpu_eoi_vector = '0;
    logic        cpu_inta_req = 1'b0;
    logic        rd_rsp_valid = 1'b0;
    logic [7:0]  rd_rsp_data = '0;

    logic        cpu_intr, cpu_nmi, cpu_inta_done;
    logic [7:0]  cpu_inta_vector;
    logic        fwd_valid, fwd_dest_logical, fwd_eoi_req;
    logic [3:0]  fwd_type;
    logic [7:0]  fwd_vector;
    logic [7:0]  fwd_dest;
    logic        rd_req_valid;
    logic [39:0] rd_req_addr;
    logic [3:0]  rd_req_bytemask;

    irq_path_router #(.DEST_W(DEST_W)) u_irq_path_router (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_type(msg_type), .msg_vector(msg_vector),
        .msg_dest_logical(msg_dest_logical), .msg_eoi_req(msg_eoi_req), .msg_dest(msg_dest),
        .cpu_eoi_valid(cpu_eoi_valid), .cpu_eoi_vector(cpu_eoi_vector),
        .cpu_inta_req(cpu_inta_req), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .cpu_intr(cpu_intr), .cpu_nmi(cpu_nmi), .cpu_inta_done(cpu_inta_done),
        .cpu_inta_vector(cpu_inta_vector), .fwd_valid(fwd_valid), .fwd_type(fwd_type),
        .fwd_vector(fwd_vector), .fwd_dest_logical(fwd_dest_logical),
        .fwd_eoi_req(fwd_eoi_req), .fwd_dest(fwd_dest),
        .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr),
        .rd_req_bytemask(rd_req_bytemask)
    );

    always #4 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // ---------------- behavioural reference ----------------
    int        ack_phase;      // 0 idle, 1 read out, 2 awaiting reply, 3 result out
    int        nmi_owed;
    bit        e_intr, e_nmi, e_rd, e_done;
    bit [7:0]  e_vec;
    bit        e_fv, e_fl, e_fe;
    bit [3:0]  e_ft;
    bit [7:0]  e_fvec, e_fd;
    bit [7:0]  eoi_q[$];

    task automatic put_eoi(input bit [7:0] v);
        e_fv = 1; e_ft = 4'b0111; e_fvec = v; e_fl = 0; e_fe = 0; e_fd = 8'hFF;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_phase = 0; nmi_owed = 0;
            e_intr = 0; e_nmi = 0; e_rd = 0; e_done = 0; e_vec = 0;
            e_fv = 0; e_ft = 0; e_fvec = 0; e_fl = 0; e_fe = 0; e_fd = 0;
            eoi_q.delete();
        end else begin
            bit pass_on, want_intr, want_nmi, replied;
            int tot;
            pass_on   = msg_valid && !msg_type[3] && (msg_type[2:0] != 3'b111);
            want_intr = msg_valid && (msg_type == 4'b1110);
            want_nmi  = msg_valid && (msg_type == 4'b1011);
            replied   = (ack_phase == 2) && rd_rsp_valid;
            if (ack_phase == 0)      begin if (cpu_inta_req) ack_phase = 1; end
            else if (ack_phase == 1) ack_phase = 2;
            else if (ack_phase == 2) begin if (rd_rsp_valid) begin ack_phase = 3; e_vec = rd_rsp_data; end end
            else                     ack_phase = 0;
            e_rd = (ack_phase == 1);
            e_done = (ack_phase == 3);
            if (want_intr) e_intr = 1; else if (replied) e_intr = 0;
            tot = nmi_owed + (want_nmi ? 1 : 0);
            if (tot > 7) tot = 7;
            if (!e_nmi && tot > 0) begin e_nmi = 1; nmi_owed = tot - 1; end
            else begin e_nmi = 0; nmi_owed = tot; end
            e_fv = 0;
            if (pass_on) begin
                e_fv = 1; e_ft = msg_type; e_fvec = msg_vector;
                e_fl = msg_dest_logical; e_fe = msg_eoi_req; e_fd = msg_dest;
                if (cpu_eoi_valid) eoi_q.push_back(cpu_eoi_vector);
            end else if (eoi_q.size() > 0) begin
                put_eoi(eoi_q.pop_front());
                if (cpu_eoi_valid) eoi_q.push_back(cpu_eoi_vector);
            end else if (cpu_eoi_valid) begin
                put_eoi(cpu_eoi_vector);
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: got %0h want %0h", req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) if (!finished) begin
        string ftag;
        ftag = (!rst_n) ? "R11" : (e_fv && e_ft == 4'b0111) ? "R10" : e_fv ? "R2" : "R8";
        check(rst_n ? "R1" : "R11", "cpu_intr", 64'(cpu_intr), 64'(e_intr));
        check(rst_n ? "R3" : "R11", "cpu_nmi", 64'(cpu_nmi), 64'(e_nmi));
        check(rst_n ? "R4" : "R11", "rd_req_valid", 64'(rd_req_valid), 64'(e_rd));
        check("R4", "rd_req_addr", 64'(rd_req_addr), e_rd ? 64'hFD_F900_0000 : 64'h0);
        check("R4", "rd_req_bytemask", 64'(rd_req_bytemask), e_rd ? 64'h1 : 64'h0);
        check(rst_n ? "R5" : "R11", "cpu_inta_done", 64'(cpu_inta_done), 64'(e_done));
        check("R5", "cpu_inta_vector", 64'(cpu_inta_vector), e_done ? 64'(e_vec) : 64'h0);
        check(ftag, "fwd_valid", 64'(fwd_valid), 64'(e_fv));
        if (e_fv)
            check(ftag, "fwd_fields",
                  {38'h0, fwd_type, fwd_vector, fwd_dest_logical, fwd_eoi_req, fwd_dest},
                  {38'h0, e_ft, e_fvec, e_fl, e_fe, e_fd});
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input bit [3:0] t, input bit [7:0] v, input bit [7:0] d,
                        input bit lg, input bit rq);
        msg_valid = 1; msg_type = t; msg_vector = v; msg_dest = d;
        msg_dest_logical = lg; msg_eoi_req = rq;
        @(negedge clk);
        msg_valid = 0;
    endtask

    task automatic pulse_inta();
        cpu_inta_req = 1; @(negedge clk); cpu_inta_req = 0;
    endtask

    task automatic reply(input bit [7:0] v);
        rd_rsp_valid = 1; rd_rsp_data = v; @(negedge clk); rd_rsp_valid = 0;
    endtask

    initial begin
        bit [7:0] lf;
        idle(3);                               // R11 reset state observed
        rst_n = 1;
        idle(2);
        send(4'b0000, 8'h41, 8'h05, 0, 1);     // R2 fixed
        send(4'b0110, 8'h00, 8'hFF, 1, 0);     // R2 APIC-path ExtInt
        send(4'b0011, 8'h02, 8'h03, 0, 0);     // R2 APIC-path NMI
        idle(2);
        send(4'b1110, 8'h00, 8'h00, 0, 0);     // R1
        idle(3);
        pulse_inta();                          // R4
        idle(2);
        pulse_inta();                          // R6 ignored while busy
        reply(8'h20);                          // R5
        idle(3);
        reply(8'h77);                          // R7 stray response
        idle(2);
        send(4'b1011, 8'h00, 8'h00, 0, 0);     // R3 back-to-back
        send(4'b1011, 8'h00, 8'h00, 0, 0);
        send(4'b1011, 8'h00, 8'h00, 0, 0);
        idle(6);
        send(4'b0111, 8'h11, 8'h01, 0, 0);     // R8
        send(4'b1111, 8'h12, 8'h01, 0, 0);     // R8
        send(4'b1000, 8'h13, 8'h01, 0, 0);     // R9
        send(4'b1101, 8'h14, 8'h01, 0, 0);     // R9
        idle(2);
        cpu_eoi_valid = 1; cpu_eoi_vector = 8'h33; @(negedge clk); cpu_eoi_valid = 0;  // R10
        idle(2);
        cpu_eoi_valid = 1; cpu_eoi_vector = 8'h44;                                     // R10 collision
        send(4'b0001, 8'h55, 8'hA0, 1, 1);
        cpu_eoi_valid = 0;
        idle(3);
        send(4'b1110, 8'h00, 8'h00, 0, 0);     // R12
        pulse_inta();
        idle(1);
        rd_rsp_valid = 1; rd_rsp_data = 8'h09;
        send(4'b1110, 8'h00, 8'h00, 0, 0);     // R12 new request with the reply
        rd_rsp_valid = 0;
        idle(3);
        pulse_inta();
        idle(2);
        reply(8'h0A);
        idle(3);
        lf = 8'hA5;
        for (int i = 0; i < 300; i++) begin    // mixed traffic, R1..R9
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            msg_valid = lf[0]; msg_type = lf[4:1]; msg_vector = lf ^ 8'h3C;
            msg_dest = ~lf; msg_dest_logical = lf[5]; msg_eoi_req = lf[6];
            cpu_inta_req = (lf[7:5] == 3'b101);
            rd_rsp_valid = (lf[3:1] == 3'b010); rd_rsp_data = lf;
            @(negedge clk);
        end
        msg_valid = 0; cpu_inta_req = 0; rd_rsp_valid = 0;
        idle(12);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule